// File: doc/BRIEF.md
# Indexed Operand Address Generator

This unit turns an indexed operand specifier into the address the data path will access. The decoder hands it the number of the chosen index register, that register's current contents, a 4-bit modifier, the operand size and a displacement byte. The unit then settles three things. It works out whether the register is stepped before or after use, and by how much. It decides whether a signed displacement takes part. It decides whether the computed location is the operand itself or holds a pointer to the operand.

A single strobe starts each computation. When the modifier asks for indirection, the unit makes exactly one 16-bit read through a request/valid memory port and uses the returned word as the final address. A one-cycle completion pulse brings out the effective address together with any register write-back. It also reports the instruction length that follows from the modifier: two bytes without a displacement and three with one. Modifier codes with no defined meaning are flagged rather than executed.

Top module: `idx_ea_unit`

## Requirements
- R1: Modifier bits [1:0] select the register update: 0 = none, 1 = post-increment, 2 = pre-decrement, 3 = illegal. Bit 2 selects indirection and bit 3 selects displacement. With bits [1:0] = 0 and bit 2 clear, `ea` equals `reg_value` (plus the displacement if bit 3 is set) and `wb_en` stays low.
- R2: Post-increment (bits [1:0] = 1) uses the unmodified register for the address. It asserts `wb_en` with `wb_value` = register + step and `wb_reg` = `reg_sel`.
- R3: Pre-decrement (bits [1:0] = 2) subtracts the step first. The decremented value is both the base of the address and `wb_value`, and `wb_en` is asserted.
- R4: The step is 1 when `word_op` = 0 (byte operand) and 2 when `word_op` = 1 (word operand). Arithmetic wraps modulo 2^16.
- R5: When modifier bit 3 is set, `disp` is sign-extended from 8 to 16 bits and added to the (possibly decremented) base, and `instr_len` = 3. When bit 3 is clear, `disp` is ignored and `instr_len` = 2.
- R6: When modifier bit 2 is set, the computed address is placed on `mem_addr` with `mem_req` held high until `mem_valid` is seen. Exactly one read is made, `ea` becomes `mem_rdata`, and `done` rises in the cycle after `mem_valid` is accepted.
- R7: When modifier bits [1:0] = 3 (codes 3, 7, B, F), `illegal` and `done` pulse together one cycle after `start`. `wb_en` stays low and no memory request is made.
- R8: Without indirection, `done` pulses for exactly one cycle, in the cycle after `start`. `wb_en` is only ever high together with `done`.
- R9: A `start` that arrives while an indirect read is outstanding is ignored. It produces no extra `done` and does not change the result.
- R10: After reset, `done`, `wb_en`, `illegal` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a computation with the current inputs |
| reg_sel | input | 4 | Index register number, returned on `wb_reg` |
| modifier | input | 4 | Update, indirection and displacement selector |
| word_op | input | 1 | 1 = word operand (step 2), 0 = byte operand (step 1) |
| reg_value | input | 16 | Current contents of the index register |
| disp | input | 8 | Signed displacement byte |
| mem_req | output | 1 | Indirect read request, held until accepted |
| mem_addr | output | 16 | Address of the pointer word |
| mem_valid | input | 1 | Read data is valid this cycle |
| mem_rdata | input | 16 | Pointer word returned by memory |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Modifier code is undefined (with `done`) |
| ea | output | 16 | Final effective address |
| wb_en | output | 1 | Write `wb_value` back to register `wb_reg` |
| wb_reg | output | 4 | Register number for the write-back |
| wb_value | output | 16 | Stepped register value |
| instr_len | output | 2 | Instruction length in bytes (2 or 3) |

## Verification
The bench targets the points where a near-miss design still looks plausible. It pre-decrements and post-increments across 0x0000 and 0xFFFF, where a missing wrap or a wrong step size moves the address by one. It uses negative displacements, which a zero-extending adder would turn into large forward offsets. It runs indirect reads with zero and several cycles of memory latency, to catch a unit that finishes before the data arrives or reads twice. Finally, it issues the four undefined modifier codes and a second start during an outstanding read; a faulty unit would write back a register or emit a spurious completion.

// File: rtl/idx_ea_pkg.sv
// Shared types for the indexed address generator.
// Assumes a 4-bit modifier whose low two bits select the register update.
package idx_ea_pkg;

    // Register update kind carried in modifier bits [1:0]
    typedef enum logic [1:0] {
        UPD_NONE = 2'd0,
        UPD_POST = 2'd1,
        UPD_PRE  = 2'd2,
        UPD_BAD  = 2'd3
    } upd_kind_e;

    // Decoded control for one computation
    typedef struct packed {
        logic disp_en;
        logic indirect;
        logic post_inc;
        logic pre_dec;
        logic illegal;
    } idx_ctl_t;

    // Sequencer state
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } seq_state_e;

endpackage

// File: rtl/idx_mod_decode.sv
// Splits the 4-bit modifier into independent control flags and the
// instruction length. Purely combinational; assumes modifier is stable
// while start is high.
module idx_mod_decode
    import idx_ea_pkg::*;
(
    input  logic [3:0] modifier,
    output idx_ctl_t   ctl,
    output logic [1:0] instr_len
);

    // Decode update kind, indirection and displacement presence
    always_comb begin
        ctl          = '0;
        ctl.disp_en  = modifier[3];
        ctl.indirect = modifier[2];
        case (upd_kind_e'(modifier[1:0]))
            UPD_POST: ctl.post_inc = 1'b1;
            UPD_PRE:  ctl.pre_dec  = 1'b1;
            UPD_BAD:  ctl.illegal  = 1'b1;
            default:  ;
        endcase
        instr_len = modifier[3] ? 2'd3 : 2'd2;
    end

endmodule

// File: rtl/idx_addr_calc.sv
// Computes the pre-indirection address and the stepped register value.
// Step is 1 for byte operands and 2 for word operands; the displacement
// is sign-extended. All arithmetic wraps at ADDR_W bits.
module idx_addr_calc
    import idx_ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 8
) (
    input  idx_ctl_t            ctl,
    input  logic                word_op,
    input  logic [ADDR_W-1:0]   reg_value,
    input  logic [DISP_W-1:0]   disp,
    output logic [ADDR_W-1:0]   addr,
    output logic [ADDR_W-1:0]   wb_value
);

    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] dec_val;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] disp_ext;

    // Operand-size dependent step and sign-extended displacement
    always_comb begin
        step     = word_op ? ADDR_W'(2) : ADDR_W'(1);
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        dec_val  = reg_value - step;
    end

    // Base selection, displacement add and write-back value
    always_comb begin
        base = ctl.pre_dec ? dec_val : reg_value;
        addr = ctl.disp_en ? base + disp_ext : base;
        if (ctl.pre_dec)
            wb_value = dec_val;
        else if (ctl.post_inc)
            wb_value = reg_value + step;
        else
            wb_value = reg_value;
    end

endmodule

// File: rtl/idx_ea_seq.sv
// Sequencer: accepts start while idle, completes direct forms in one
// cycle, and for indirect forms holds one memory request until valid.
// Assumes mem_rdata is valid in the same cycle as mem_valid.
module idx_ea_seq
    import idx_ea_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int REG_ID_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  idx_ctl_t            ctl,
    input  logic [1:0]          len_in,
    input  logic [REG_ID_W-1:0] reg_sel,
    input  logic [ADDR_W-1:0]   calc_addr,
    input  logic [ADDR_W-1:0]   calc_wb,
    input  logic                mem_valid,
    input  logic [ADDR_W-1:0]   mem_rdata,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                done,
    output logic                illegal,
    output logic [ADDR_W-1:0]   ea,
    output logic                wb_en,
    output logic [REG_ID_W-1:0] wb_reg,
    output logic [ADDR_W-1:0]   wb_value,
    output logic [1:0]          instr_len
);

    seq_state_e state;
    logic       pend_wb;

    // Request is asserted for as long as the pointer read is outstanding
    assign mem_req = (state == ST_FETCH);

    // State, result registers and one-cycle completion pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pend_wb   <= 1'b0;
            mem_addr  <= '0;
            done      <= 1'b0;
            illegal   <= 1'b0;
            ea        <= '0;
            wb_en     <= 1'b0;
            wb_reg    <= '0;
            wb_value  <= '0;
            instr_len <= 2'd2;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            wb_en   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        instr_len <= len_in;
                        if (ctl.illegal) begin
                            done    <= 1'b1;
                            illegal <= 1'b1;
                        end else begin
                            wb_reg   <= reg_sel;
                            wb_value <= calc_wb;
                            if (ctl.indirect) begin
                                state    <= ST_FETCH;
                                mem_addr <= calc_addr;
                                pend_wb  <= ctl.post_inc | ctl.pre_dec;
                            end else begin
                                ea    <= calc_addr;
                                done  <= 1'b1;
                                wb_en <= ctl.post_inc | ctl.pre_dec;
                            end
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_valid) begin
                        ea    <= mem_rdata;
                        done  <= 1'b1;
                        wb_en <= pend_wb;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/idx_ea_unit.sv
// Indexed operand address generator top level. Ties the modifier
// decoder, the address arithmetic and the sequencer together.
// Assumes inputs other than mem_* are valid only in the start cycle.
module idx_ea_unit
    import idx_ea_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DISP_W   = 8,
    parameter int REG_ID_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [REG_ID_W-1:0] reg_sel,
    input  logic [3:0]          modifier,
    input  logic                word_op,
    input  logic [ADDR_W-1:0]   reg_value,
    input  logic [DISP_W-1:0]   disp,
    output logic                mem_req,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic                mem_valid,
    input  logic [ADDR_W-1:0]   mem_rdata,
    output logic                done,
    output logic                illegal,
    output logic [ADDR_W-1:0]   ea,
    output logic                wb_en,
    output logic [REG_ID_W-1:0] wb_reg,
    output logic [ADDR_W-1:0]   wb_value,
    output logic [1:0]          instr_len
);

    idx_ctl_t          ctl;
    logic [1:0]        len_dec;
    logic [ADDR_W-1:0] calc_addr;
    logic [ADDR_W-1:0] calc_wb;

    idx_mod_decode u_dec (
        .modifier  (modifier),
        .ctl       (ctl),
        .instr_len (len_dec)
    );

    idx_addr_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_calc (
        .ctl       (ctl),
        .word_op   (word_op),
        .reg_value (reg_value),
        .disp      (disp),
        .addr      (calc_addr),
        .wb_value  (calc_wb)
    );

    idx_ea_seq #(.ADDR_W(ADDR_W), .REG_ID_W(REG_ID_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ctl       (ctl),
        .len_in    (len_dec),
        .reg_sel   (reg_sel),
        .calc_addr (calc_addr),
        .calc_wb   (calc_wb),
        .mem_valid (mem_valid),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .done      (done),
        .illegal   (illegal),
        .ea        (ea),
        .wb_en     (wb_en),
        .wb_reg    (wb_reg),
        .wb_value  (wb_value),
        .instr_len (instr_len)
    );

endmodule

// File: rtl/idx_ea_unit_chk.sv
// Protocol checker for idx_ea_unit, bound to every instance.
// Assumes synchronous active-low reset.
module idx_ea_unit_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_valid,
    input logic              done,
    input logic              illegal,
    input logic              wb_en
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done && !mem_req |=> !done) else $error("done longer than one cycle"); // R8
    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done) else $error("write-back without done"); // R8
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done && !wb_en && !mem_req) else $error("illegal with side effect"); // R7
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid |=> mem_req) else $error("request dropped early"); // R6
    AST_REQ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_valid |=> $stable(mem_addr)) else $error("request address moved"); // R6
    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_valid |=> done && !mem_req) else $error("no done after read"); // R6
    AST_NO_DONE_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !done) else $error("done during outstanding read"); // R9

endmodule

bind idx_ea_unit idx_ea_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid),
    .done      (done),
    .illegal   (illegal),
    .wb_en     (wb_en)
);

// File: tb/idx_ea_unit_test.sv
module idx_ea_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [3:0]  modifier = '0;
    logic        word_op = 1'b0;
    logic [15:0] reg_value = '0;
    logic [7:0]  disp = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        done, illegal, wb_en;
    logic [15:0] ea, wb_value;
    logic [3:0]  wb_reg;
    logic [1:0]  instr_len;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int reads = 0;
    int wait_cnt = 0;
    logic [15:0] last_addr = '0;

    idx_ea_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .reg_sel(reg_sel),
        .modifier(modifier), .word_op(word_op), .reg_value(reg_value),
        .disp(disp), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .done(done),
        .illegal(illegal), .ea(ea), .wb_en(wb_en), .wb_reg(wb_reg),
        .wb_value(wb_value), .instr_len(instr_len)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] ptr_of(input logic [15:0] a);
        return a ^ 16'h5A3C;
    endfunction

    // Memory responder: answers a request after lat idle cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !mem_valid) begin
                if (wait_cnt >= lat) begin
                    mem_valid = 1'b1;
                    mem_rdata = ptr_of(mem_addr);
                    last_addr = mem_addr;
                    reads++;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end else begin
                mem_valid = 1'b0;
                wait_cnt = 0;
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Runs one computation and compares every output against the model
    task automatic run_case(input string req, input logic [3:0] rs,
                            input logic [3:0] md, input logic wo,
                            input logic [15:0] rv, input logic [7:0] dp,
                            input int latency);
        logic [15:0] step, base, addr, wbv;
        logic        exp_wb, bad;
        int          cyc, rd0;
        step   = wo ? 16'd2 : 16'd1;
        bad    = (md[1:0] == 2'd3);
        base   = (md[1:0] == 2'd2) ? rv - step : rv;
        addr   = md[3] ? base + {{8{dp[7]}}, dp} : base;
        wbv    = (md[1:0] == 2'd1) ? rv + step : (md[1:0] == 2'd2) ? rv - step : rv;
        exp_wb = (md[1:0] == 2'd1) || (md[1:0] == 2'd2);
        lat = latency;
        rd0 = reads;
        @(negedge clk);
        reg_sel = rs; modifier = md; word_op = wo; reg_value = rv; disp = dp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        reg_value = 16'hDEAD; disp = 8'h77;
        cyc = 0;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        check(req, "done", {31'd0, done}, 32'd1);
        check(req, "illegal", {31'd0, illegal}, {31'd0, bad});
        check(req, "instr_len", {30'd0, instr_len}, md[3] ? 32'd3 : 32'd2);
        if (bad) begin
            check(req, "wb_en", {31'd0, wb_en}, 32'd0);
            check(req, "reads", reads - rd0, 32'd0);
            check(req, "latency", cyc, 32'd0);
        end else begin
            check(req, "wb_en", {31'd0, wb_en}, {31'd0, exp_wb});
            if (exp_wb) begin
                check(req, "wb_value", {16'd0, wb_value}, {16'd0, wbv});
                check(req, "wb_reg", {28'd0, wb_reg}, {28'd0, rs});
            end
            if (md[2]) begin
                check(req, "read count", reads - rd0, 32'd1);
                check(req, "read addr", {16'd0, last_addr}, {16'd0, addr});
                check(req, "ea", {16'd0, ea}, {16'd0, ptr_of(addr)});
                check(req, "latency", cyc, latency + 1);
            end else begin
                check(req, "reads", reads - rd0, 32'd0);
                check(req, "ea", {16'd0, ea}, {16'd0, addr});
                check(req, "latency", cyc, 32'd0);
            end
        end
        @(negedge clk);
        check(req, "done pulse width", {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset_state();
        check("R10", "done", {31'd0, done}, 32'd0);
        check("R10", "wb_en", {31'd0, wb_en}, 32'd0);
        check("R10", "illegal", {31'd0, illegal}, 32'd0);
        check("R10", "mem_req", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_plain();
        run_case("R1", 4'h4, 4'h0, 1'b1, 16'h1234, 8'hFF, 0);  // disp ignored
        run_case("R8", 4'h2, 4'h0, 1'b0, 16'h0000, 8'h00, 0);
    endtask

    task automatic t_post_inc();
        run_case("R2", 4'h6, 4'h1, 1'b0, 16'h00FF, 8'h00, 0);
        run_case("R4", 4'h8, 4'h1, 1'b1, 16'hFFFF, 8'h00, 0);  // wraps to 1
    endtask

    task automatic t_pre_dec();
        run_case("R3", 4'hA, 4'h2, 1'b1, 16'h0000, 8'h00, 0);  // wraps to FFFE
        run_case("R4", 4'h0, 4'h2, 1'b0, 16'h8000, 8'h00, 0);
    endtask

    task automatic t_disp();
        run_case("R5", 4'h2, 4'h8, 1'b1, 16'h1000, 8'h7F, 0);
        run_case("R5", 4'h4, 4'hA, 1'b1, 16'h1000, 8'h80, 0);  // -128
        run_case("R5", 4'h6, 4'h9, 1'b0, 16'h0005, 8'hF0, 0);
    endtask

    task automatic t_indirect();
        run_case("R6", 4'h0, 4'h4, 1'b1, 16'h2000, 8'h00, 0);
        run_case("R6", 4'h2, 4'h5, 1'b0, 16'h3001, 8'h00, 3);
        run_case("R6", 4'h4, 4'h6, 1'b1, 16'h4000, 8'h00, 1);
        run_case("R6", 4'h6, 4'hC, 1'b1, 16'h5000, 8'hFE, 2);
        run_case("R6", 4'h8, 4'hE, 1'b0, 16'h0001, 8'h03, 5);
        run_case("R6", 4'hA, 4'hD, 1'b1, 16'hFFFE, 8'h02, 0);
    endtask

    task automatic t_illegal();
        for (int k = 0; k < 4; k++) begin
            run_case("R7", 4'h2, {k[1:0], 2'b11}, 1'b1, 16'h4444, 8'h10, 0);
        end
    endtask

    // A second start during an outstanding read must be dropped
    task automatic t_busy_start();
        int rd0, dones;
        lat = 6;
        rd0 = reads;
        dones = 0;
        @(negedge clk);
        reg_sel = 4'h4; modifier = 4'h4; word_op = 1'b1; reg_value = 16'h1000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        reg_sel = 4'h6; modifier = 4'h1; reg_value = 16'h2222;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 20; c++) begin
            if (done) begin
                dones++;
                if (dones == 1)
                    check("R9", "ea", {16'd0, ea}, {16'd0, ptr_of(16'h1000)});
            end
            @(negedge clk);
        end
        check("R9", "done count", dones, 32'd1);
        check("R9", "read count", reads - rd0, 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_plain();
        t_post_inc();
        t_pre_dec();
        t_disp();
        t_indirect();
        t_illegal();
        t_busy_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule